// File: doc/BRIEF.md
# BCD calendar clock counter

This block keeps wall-clock time and a calendar date in packed BCD registers. It holds seconds, minutes, hours in 24-hour form, a one-hot weekday, day of month, month and a two-digit year. A divider counts pulses of a reference enable, nominally 32.768 kHz, and makes a once-per-second advance. The advance ripples through the fields with per-month day limits and a leap rule of every fourth year.

A host reaches every field through a small synchronous register port. Writes land on the next clock edge, and reads are combinational from the selected address. A control register holds a stop bit that freezes all counting. It also holds a sticky low-voltage flag that is set at power-on and tells software the contents are not yet trusted. Two single-cycle strobes, one per second advance and one per minute advance, are provided for other logic.

Top module: `rtc_calendar`

## Requirements
- R1: After reset, the registers read seconds 0x00, minutes 0x00, hours 0x00, weekday 0x01, day 0x01, month 0x01, year 0x00 and control 0x02 (flag set, stop clear). The address map is 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day, 5 month, 6 year, 7 control.
- R2: While running, the seconds field advances once for every REF_DIV cycles in which `ref_tick_i` is high. `sec_strobe_o` is high for exactly the one cycle in which the new seconds value is first visible.
- R3: Seconds and minutes count 00..59 in BCD, and hours count 00..23. Seconds going from 59 to 00 advances minutes and raises `min_strobe_o` in that same cycle. Minutes going from 59 to 00 advances hours.
- R4: When hours go from 23 to 00 (midnight), the day advances. Day wraps to 01 after 30 for months 04, 06, 09 and 11. For month 02 it wraps after 29 when a valid BCD year is a multiple of 4, and after 28 otherwise. For every other month it wraps after 31.
- R5: The wrap of day advances the month, which goes from 12 to 01. Month 12 to 01 advances the year, which goes from 99 to 00.
- R6: At midnight the weekday field rotates left by one position, so bit 6 moves to bit 0.
- R7: While control bit 0 (stop) is 1, the divider and all fields hold their values and no strobe fires. Host writes still take effect.
- R8: Control bit 1 is the low-voltage flag. Writing 0 to it clears it, and writing 1 leaves it unchanged.
- R9: Control bits 7..2 always read 0, whatever is written to them.
- R10: Each field stores only its own width: seconds 7, minutes 7, hours 6, weekday 7, day 6, month 5 and year 8 bits. Higher bits are dropped on write and read as 0.
- R11: A write to the seconds field clears the divider and cancels any second advance in that cycle. The next advance follows REF_DIV reference pulses later.
- R12: A field at or above its wrap value moves to its floor on the next advance: 00 for time and year, 01 for day and month. Otherwise a low digit of 9 or more becomes 0 and carries into the tens digit, and any other low digit increments.
- R13: A host write to a field takes priority over its advance in the same cycle, and that field passes no carry onward in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| ref_tick_i | input | 1 | Reference pulse enable, one cycle per reference period |
| wr_en_i | input | 1 | Host write strobe |
| addr_i | input | 3 | Register address for both read and write |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Combinational read data of the addressed register |
| sec_strobe_o | output | 1 | One-cycle pulse on each second advance |
| min_strobe_o | output | 1 | One-cycle pulse on each minute advance |

## Verification
The bench builds the block with REF_DIV set to 4, so one second takes four clocks when the reference is held high. This brings minute, midnight, month-end and year-end rollovers within a few dozen cycles once the host has preloaded values close to each boundary. The short divider also lets writes to seconds land at every phase of the divider, and lets gapped reference patterns be checked against the second count.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  typedef enum logic [2:0] {
    REG_SEC  = 3'd0,
    REG_MIN  = 3'd1,
    REG_HOUR = 3'd2,
    REG_WDAY = 3'd3,
    REG_DAY  = 3'd4,
    REG_MON  = 3'd5,
    REG_YEAR = 3'd6,
    REG_CTRL = 3'd7
  } reg_addr_e;

  localparam int unsigned N_REGS = 8;
  localparam int unsigned DAYS_PER_WEEK = 7;

  localparam logic [7:0] SEC_LAST  = 8'h59;
  localparam logic [7:0] MIN_LAST  = 8'h59;
  localparam logic [7:0] HOUR_LAST = 8'h23;
  localparam logic [7:0] MON_LAST  = 8'h12;
  localparam logic [7:0] YEAR_LAST = 8'h99;

  // valid BCD year divisible by 4: even tens with 0/4/8, odd tens with 2/6
  function automatic logic bcd_year_leap(input logic [7:0] yr);
    logic lo_even_set, lo_odd_set;
    lo_even_set = (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
    lo_odd_set  = (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
    return yr[4] ? lo_odd_set : lo_even_set;
  endfunction

  function automatic logic [7:0] month_last_day(input logic [7:0] mon, input logic leap);
    logic [7:0] last;
    case (mon)
      8'h02:                      last = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last = 8'h30;
      default:                    last = 8'h31;
    endcase
    return last;
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned DIV = 32768
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_tick_i,
  input  logic run_i,
  input  logic clear_i,
  output logic tick_o
);

  localparam int unsigned CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             adv;
  logic             wrap;

  assign adv    = ref_tick_i & run_i;
  assign wrap   = (cnt_q == LAST);
  assign tick_o = adv & wrap & ~clear_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (adv)     cnt_q <= wrap ? '0 : cnt_q + 1'b1;
  end

endmodule

// File: rtl/rtc_bcd_counter.sv
module rtc_bcd_counter #(
  parameter int unsigned W       = 7,
  parameter logic [7:0]  FLOOR   = 8'h00,
  parameter logic [7:0]  RST_VAL = 8'h00
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic [7:0]   limit_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] value_o,
  output logic         carry_o
);

  logic [W-1:0] val_q;
  logic [W-1:0] val_nxt;
  logic [7:0]   val_ext;
  logic         at_limit;

  assign val_ext  = 8'(val_q);
  assign at_limit = (val_ext >= limit_i);
  assign carry_o  = inc_i & at_limit & ~wr_i;
  assign value_o  = val_q;

  // out-of-range values fall to the floor, so a bad load never stalls
  always_comb begin
    if (at_limit)                val_nxt = FLOOR[W-1:0];
    else if (val_q[3:0] >= 4'd9) val_nxt = {val_q[W-1:4] + 1'b1, 4'h0};
    else                         val_nxt = {val_q[W-1:4], val_q[3:0] + 4'd1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    val_q <= RST_VAL[W-1:0];
    else if (wr_i)  val_q <= wdata_i;
    else if (inc_i) val_q <= val_nxt;
  end

  AST_ADV_DIGIT_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && !wr_i |=> value_o[3:0] <= 4'd9); // R12

  AST_WRITE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> value_o == $past(wdata_i)); // R13

endmodule

// File: rtl/rtc_weekday.sv
module rtc_weekday #(
  parameter int unsigned DAYS = 7
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            adv_i,
  input  logic            wr_i,
  input  logic [DAYS-1:0] wdata_i,
  output logic [DAYS-1:0] wday_o
);

  logic [DAYS-1:0] wday_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    wday_q <= DAYS'(1);
    else if (wr_i)  wday_q <= wdata_i;
    else if (adv_i) wday_q <= {wday_q[DAYS-2:0], wday_q[DAYS-1]};
  end

  assign wday_o = wday_q;

  AST_WDAY_ROTATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && !wr_i |=> $countones(wday_o) == $countones($past(wday_o))
                       && wday_o[0] == $past(wday_o[DAYS-1])); // R6

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_cal_pkg::*;
#(
  parameter int unsigned REF_DIV = 32768
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ref_tick_i,
  input  logic       wr_en_i,
  input  logic [2:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       sec_strobe_o,
  output logic       min_strobe_o
);

  logic [N_REGS-1:0] wr_sel;
  logic              stop_q, lowv_q;
  logic              sec_tick;
  logic              sec_carry, min_carry, hour_carry, day_carry, mon_carry, year_carry;
  logic [6:0]        sec_val, min_val;
  logic [5:0]        hour_val, day_val;
  logic [4:0]        mon_val;
  logic [7:0]        year_val;
  logic [DAYS_PER_WEEK-1:0] wday_val;
  logic [7:0]        day_limit;
  logic              sec_strobe_q, min_strobe_q;

  assign wr_sel = wr_en_i ? (N_REGS'(1) << addr_i) : '0;

  rtc_prescaler #(.DIV(REF_DIV)) u_pre (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ref_tick_i (ref_tick_i),
    .run_i      (~stop_q),
    .clear_i    (wr_sel[REG_SEC]),
    .tick_o     (sec_tick)
  );

  rtc_bcd_counter #(.W(7), .FLOOR(8'h00), .RST_VAL(8'h00)) u_sec (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(sec_tick), .limit_i(SEC_LAST),
    .wr_i(wr_sel[REG_SEC]), .wdata_i(wdata_i[6:0]), .value_o(sec_val), .carry_o(sec_carry)
  );

  rtc_bcd_counter #(.W(7), .FLOOR(8'h00), .RST_VAL(8'h00)) u_min (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(sec_carry), .limit_i(MIN_LAST),
    .wr_i(wr_sel[REG_MIN]), .wdata_i(wdata_i[6:0]), .value_o(min_val), .carry_o(min_carry)
  );

  rtc_bcd_counter #(.W(6), .FLOOR(8'h00), .RST_VAL(8'h00)) u_hour (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(min_carry), .limit_i(HOUR_LAST),
    .wr_i(wr_sel[REG_HOUR]), .wdata_i(wdata_i[5:0]), .value_o(hour_val), .carry_o(hour_carry)
  );

  rtc_weekday #(.DAYS(DAYS_PER_WEEK)) u_wday (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(hour_carry),
    .wr_i(wr_sel[REG_WDAY]), .wdata_i(wdata_i[DAYS_PER_WEEK-1:0]), .wday_o(wday_val)
  );

  assign day_limit = month_last_day(8'(mon_val), bcd_year_leap(year_val));

  rtc_bcd_counter #(.W(6), .FLOOR(8'h01), .RST_VAL(8'h01)) u_day (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(hour_carry), .limit_i(day_limit),
    .wr_i(wr_sel[REG_DAY]), .wdata_i(wdata_i[5:0]), .value_o(day_val), .carry_o(day_carry)
  );

  rtc_bcd_counter #(.W(5), .FLOOR(8'h01), .RST_VAL(8'h01)) u_mon (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(day_carry), .limit_i(MON_LAST),
    .wr_i(wr_sel[REG_MON]), .wdata_i(wdata_i[4:0]), .value_o(mon_val), .carry_o(mon_carry)
  );

  rtc_bcd_counter #(.W(8), .FLOOR(8'h00), .RST_VAL(8'h00)) u_year (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(mon_carry), .limit_i(YEAR_LAST),
    .wr_i(wr_sel[REG_YEAR]), .wdata_i(wdata_i), .value_o(year_val), .carry_o(year_carry)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stop_q <= 1'b0;
      lowv_q <= 1'b1;
    end else if (wr_sel[REG_CTRL]) begin
      stop_q <= wdata_i[0];
      lowv_q <= lowv_q & wdata_i[1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_strobe_q <= 1'b0;
      min_strobe_q <= 1'b0;
    end else begin
      sec_strobe_q <= sec_tick;
      min_strobe_q <= sec_carry;
    end
  end

  assign sec_strobe_o = sec_strobe_q;
  assign min_strobe_o = min_strobe_q;

  always_comb begin
    case (reg_addr_e'(addr_i))
      REG_SEC:  rdata_o = 8'(sec_val);
      REG_MIN:  rdata_o = 8'(min_val);
      REG_HOUR: rdata_o = 8'(hour_val);
      REG_WDAY: rdata_o = 8'(wday_val);
      REG_DAY:  rdata_o = 8'(day_val);
      REG_MON:  rdata_o = 8'(mon_val);
      REG_YEAR: rdata_o = year_val;
      REG_CTRL: rdata_o = {6'b0, lowv_q, stop_q};
      default:  rdata_o = 8'h00;
    endcase
  end

  AST_STOP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_q && !wr_sel[REG_SEC] |=> $stable(sec_val) && !sec_strobe_o); // R7

  AST_MIN_STROBE_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    min_strobe_o |-> sec_strobe_o && sec_val == 7'h00); // R3

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lowv_q |=> !lowv_q); // R8

  AST_SEC_WRITE_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_sel[REG_SEC] |=> !sec_strobe_o); // R11

  AST_YEAR_WRAP_FROM_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    year_carry |=> mon_val == 5'h01); // R5

endmodule

// File: tb/rtc_calendar_bench.sv
`timescale 1ns/1ps
module rtc_calendar_bench;
  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ref_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       ss, ms;

  int vectors = 0;
  int errors = 0;
  bit done = 0;

  int m_sec, m_min, m_hour, m_wday, m_day, m_mon, m_year, m_pre, m_stop, m_flag;
  bit e_ss, e_ms;
  string scen = "R1";

  always #2.5 clk = ~clk;

  rtc_calendar #(.REF_DIV(DIV)) u_rtc_calendar (
    .clk_i(clk), .rst_ni(rst_ni), .ref_tick_i(ref_tick), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .sec_strobe_o(ss), .min_strobe_o(ms)
  );

  function automatic int nxt(int v, int lim, int fl);
    int lo = v % 16;
    int hi = v / 16;
    if (v >= lim) return fl;
    if (lo >= 9) return (hi + 1) * 16;
    return v + 1;
  endfunction

  function automatic int last_day(int mo, int yr);
    int y = (yr / 16) * 10 + (yr % 16);
    if (mo == 'h02) return (y % 4 == 0) ? 'h29 : 'h28;
    if (mo == 'h04 || mo == 'h06 || mo == 'h09 || mo == 'h11) return 'h30;
    return 'h31;
  endfunction

  function automatic int exp_rd(int a);
    case (a)
      0: return m_sec;
      1: return m_min;
      2: return m_hour;
      3: return m_wday;
      4: return m_day;
      5: return m_mon;
      6: return m_year;
      default: return m_flag * 2 + m_stop;
    endcase
  endfunction

  function automatic string field_req(int a);
    case (a)
      0, 1, 2: return "R3";
      3: return "R6";
      4: return "R4";
      5, 6: return "R5";
      default: return "R8";
    endcase
  endfunction

  task automatic model_reset();
    m_sec = 0; m_min = 0; m_hour = 0; m_wday = 1; m_day = 1; m_mon = 1; m_year = 0;
    m_pre = 0; m_stop = 0; m_flag = 1; e_ss = 0; e_ms = 0;
  endtask

  task automatic model(bit w, int a, int d, bit r);
    int ws = w ? a : -1;
    bit tick = r && !m_stop && m_pre == DIV - 1 && ws != 0;
    bit c0, c1, c2, c3, c4;
    int lim = last_day(m_mon, m_year);
    c0 = tick && m_sec >= 'h59;
    c1 = c0 && m_min >= 'h59 && ws != 1;
    c2 = c1 && m_hour >= 'h23 && ws != 2;
    c3 = c2 && m_day >= lim && ws != 4;
    c4 = c3 && m_mon >= 'h12 && ws != 5;
    if (ws == 0) m_pre = 0;
    else if (r && !m_stop) m_pre = (m_pre == DIV - 1) ? 0 : m_pre + 1;
    if (ws == 0) m_sec = d & 'h7F; else if (tick) m_sec = nxt(m_sec, 'h59, 0);
    if (ws == 1) m_min = d & 'h7F; else if (c0) m_min = nxt(m_min, 'h59, 0);
    if (ws == 2) m_hour = d & 'h3F; else if (c1) m_hour = nxt(m_hour, 'h23, 0);
    if (ws == 3) m_wday = d & 'h7F;
    else if (c2) m_wday = ((m_wday << 1) & 'h7F) | ((m_wday >> 6) & 1);
    if (ws == 4) m_day = d & 'h3F; else if (c2) m_day = nxt(m_day, lim, 1);
    if (ws == 5) m_mon = d & 'h1F; else if (c3) m_mon = nxt(m_mon, 'h12, 1);
    if (ws == 6) m_year = d & 'hFF; else if (c4) m_year = nxt(m_year, 'h99, 0);
    if (ws == 7) begin
      m_stop = d & 1;
      m_flag = m_flag & ((d >> 1) & 1);
    end
    e_ss = tick;
    e_ms = c0;
  endtask

  task automatic check();
    int a = int'(addr);
    vectors += 3;
    if (int'(rdata) != exp_rd(a)) begin
      errors++;
      $display("FAIL %s [%s] addr %0d rdata actual %02h expected %02h",
               field_req(a), scen, a, rdata, exp_rd(a));
    end
    if (ss !== e_ss) begin
      errors++;
      $display("FAIL R2 [%s] sec_strobe actual %0b expected %0b", scen, ss, e_ss);
    end
    if (ms !== e_ms) begin
      errors++;
      $display("FAIL R3 [%s] min_strobe actual %0b expected %0b", scen, ms, e_ms);
    end
  endtask

  task automatic step(bit w, int a, int d, bit r);
    @(negedge clk);
    check();
    wr_en = w; addr = 3'(a); wdata = 8'(d); ref_tick = r;
    model(w, a, d, r);
  endtask

  // gap < 0: no reference; gap == 0: every cycle; else skip every gap-th
  task automatic run(int n, int gap);
    for (int i = 0; i < n; i++) begin
      bit r = (gap < 0) ? 1'b0 : (gap == 0) ? 1'b1 : ((i % gap) != 0);
      step(0, i % 8, 0, r);
    end
  endtask

  task automatic wr(int a, int d);
    step(1, a, d, 1);
  endtask

  task automatic set_date(int y, int mo, int dd, int h, int mi, int s);
    wr(6, y); wr(5, mo); wr(4, dd); wr(2, h); wr(1, mi); wr(0, s);
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    scen = "R1";  // reset values of every register
    run(16, -1);

    scen = "R2";  // steady and gapped reference
    run(48, 0);
    run(60, 3);

    scen = "R3";  // minute, hour, midnight, weekday, month and year wrap
    wr(3, 'h40);
    set_date('h99, 'h12, 'h31, 'h23, 'h59, 'h50);
    run(60, 0);   // R5 R6

    scen = "R4";  // leap February, plain February, 30-day month
    set_date('h24, 'h02, 'h28, 'h23, 'h59, 'h57);
    run(24, 0);
    set_date('h24, 'h02, 'h29, 'h23, 'h59, 'h57);
    run(24, 0);
    set_date('h23, 'h02, 'h28, 'h23, 'h59, 'h57);
    run(24, 0);
    set_date('h00, 'h02, 'h28, 'h23, 'h59, 'h57);
    run(24, 0);
    set_date('h07, 'h04, 'h30, 'h23, 'h59, 'h57);
    run(24, 0);
    set_date('h07, 'h11, 'h30, 'h23, 'h59, 'h57);
    run(24, 0);

    scen = "R7";  // stop freezes, writes still land
    wr(7, 'h03);
    run(24, 0);
    wr(0, 'h10);
    run(16, 0);
    wr(7, 'h02);
    run(24, 0);

    scen = "R8";  // flag clears on 0, 1 cannot set it
    wr(7, 'h00);
    run(8, 0);
    wr(7, 'h02);
    run(8, 0);

    scen = "R9";  // upper control bits read 0
    wr(7, 'hFC);
    run(8, 0);

    scen = "R10"; // width masking on all fields, then R12 recovery
    for (int a = 0; a < 7; a++) wr(a, 'hFF);
    run(16, -1);
    scen = "R12";
    run(24, 0);
    wr(0, 'h0C);
    run(12, 0);
    wr(1, 'h5A);
    wr(0, 'h59);
    run(12, 0);

    scen = "R11"; // seconds write at each divider phase
    for (int k = 0; k < 8; k++) begin
      run(k + 1, 0);
      wr(0, 'h20 + k);
    end
    run(12, 0);

    scen = "R13"; // minute write coinciding with the minute carry
    wr(2, 'h05);
    wr(1, 'h59);
    wr(0, 'h59);
    run(3, 0);
    wr(1, 'h30);
    run(8, 0);
    wr(0, 'h58);
    run(7, 0);
    wr(0, 'h11);
    run(8, 0);

    step(0, 0, 0, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog expired: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule